// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes in asynchronous serial frames on a single line and holds each finished byte in a receive data register. That register is separate from the shift register, so a new frame can arrive while software still holds the previous byte. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A programmable divider produces a 16x oversampling tick. The receiver locks its bit timing to the falling edge of the start bit and samples every later bit once, at its middle.

Software reaches the block through a small register port with four locations. Location 0 holds the received byte (read only). Location 1 holds the status flags, and writing 1 to a status bit clears it. Location 2 holds the control bits. Location 3 holds the divider. Two level interrupt outputs follow the flags: one for received data and one shared by all three error kinds. Both are gated by a single enable bit.

Top module: `serial_rx_top`

## Requirements
- R1: The line idles high. A good frame (start bit 0, D0 first through D7, stop bit 1) places its byte at location 0 and sets status bit 0 (data ready).
- R2: A start bit is accepted only if the line is still low at the eighth oversampling tick after the falling edge. A shorter low pulse returns the receiver to idle and changes no flag and no data.
- R3: The oversampling tick fires once every DIV+1 clocks, where DIV is location 3 (reset value 0). Each data bit is sampled 16 ticks after the previous one.
- R4: Control bit 0 enables the parity bit and control bit 1 selects odd parity (1) or even parity (0). A parity mismatch sets status bit 2 and still copies the byte to location 0, but does not set data ready. With parity disabled, the stop bit follows D7 directly.
- R5: A stop bit sampled as 0 sets status bit 3 and still copies the byte to location 0, without setting data ready.
- R6: If a frame completes while data ready is set, status bit 1 (overrun) is set, location 0 keeps its old byte and data ready stays set. The new frame's parity and stop results are not recorded.
- R7: Writing 1 to a bit of location 1 clears that flag. When a flag is set and cleared in the same cycle, the set wins. A clear of data ready in the same cycle as a frame completion counts as a read in time, so no overrun occurs.
- R8: Control bit 2 is the interrupt enable. irq_rx equals data ready AND enable. irq_err equals (overrun OR parity error OR framing error) AND enable. Both are registered and follow the flags one clock later.
- R9: Synchronous active-high reset clears the data register, all flags, the control bits and the divider, and returns the receiver to idle.
- R10: rd_data is registered and shows the location selected by addr one clock after addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Serial receive line, idle high |
| addr | input | 2 | Register location for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_rx | output | 1 | Received-data interrupt level |
| irq_err | output | 1 | Shared error interrupt level |

## Verification
Two things can happen in the same cycle: a frame completion that sets data ready, and a software write that clears it. The bench provokes this by first leaving a byte pending. It then sends a second frame and issues the clear at each clock offset in a window that spans the completion. After every trial the outcome must be exactly one of two states. If the clear came in time, the new byte is present with only data ready set. If the clear came late, the old byte is present with only overrun set. Any other outcome, such as a lost ready flag, counts as a miscompare, and both outcomes must appear across the window.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  typedef struct packed {
    logic par_err;
    logic frm_err;
  } rx_err_t;

  localparam logic [1:0] LOC_DATA = 2'd0;
  localparam logic [1:0] LOC_STAT = 2'd1;
  localparam logic [1:0] LOC_CTRL = 2'd2;
  localparam logic [1:0] LOC_DIV  = 2'd3;

  localparam int ST_RDY = 0;
  localparam int ST_OVR = 1;
  localparam int ST_PER = 2;
  localparam int ST_FER = 3;
  localparam int ST_N   = 4;

  localparam int CT_PEN = 0;
  localparam int CT_ODD = 1;
  localparam int CT_IE  = 2;
  localparam int CT_N   = 3;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt >= div);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] data,
  output rx_err_t       err
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] MID   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTB = BW'(DW - 1);

  rx_state_t     st;
  logic [1:0]    rx_q;
  logic          rx_s;
  logic [CW-1:0] scnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic          par_bit;

  assign rx_s = rx_q[1];
  assign data = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 2'b11;
      st      <= RX_IDLE;
      scnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      err     <= '0;
    end else begin
      rx_q <= {rx_q[0], rx};
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: begin
            scnt <= '0;
            if (!rx_s) st <= RX_START;
          end
          RX_START: begin
            if (scnt == MID) begin
              scnt <= '0;
              bcnt <= '0;
              st   <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (scnt == LAST) begin
              scnt  <= '0;
              shreg <= {rx_s, shreg[DW-1:1]};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == LASTB) st <= par_en ? RX_PAR : RX_STOP;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (scnt == LAST) begin
              scnt    <= '0;
              par_bit <= rx_s;
              st      <= RX_STOP;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (scnt == LAST) begin
              scnt        <= '0;
              done        <= 1'b1;
              err.frm_err <= !rx_s;
              err.par_err <= par_en & ((^shreg ^ par_bit) != par_odd);
              st          <= RX_IDLE;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && tick && scnt == MID && rx_s) |=> (st == RX_IDLE));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] DIV_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          done,
  input  logic [DW-1:0] frame_data,
  input  rx_err_t       err,
  output logic [DW-1:0] div,
  output logic          par_en,
  output logic          par_odd,
  output logic [DW-1:0] rd_data,
  output logic          irq_rx,
  output logic          irq_err
);
  logic [DW-1:0]   data_q;
  logic [ST_N-1:0] flags;
  logic [CT_N-1:0] ctrl;
  logic [ST_N-1:0] clr;
  logic [ST_N-1:0] set;
  logic            busy;
  logic            take;

  assign clr  = (wr_en && addr == LOC_STAT) ? wr_data[ST_N-1:0] : '0;
  assign busy = flags[ST_RDY] & ~clr[ST_RDY];
  assign take = done & ~busy;

  always_comb begin
    set         = '0;
    set[ST_OVR] = done & busy;
    set[ST_PER] = take & err.par_err;
    set[ST_FER] = take & err.frm_err;
    set[ST_RDY] = take & ~err.par_err & ~err.frm_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      flags  <= '0;
      ctrl   <= '0;
      div    <= DIV_RST;
    end else begin
      flags <= (flags & ~clr) | set;
      if (take) data_q <= frame_data;
      if (wr_en && addr == LOC_CTRL) ctrl <= wr_data[CT_N-1:0];
      if (wr_en && addr == LOC_DIV)  div  <= wr_data;
    end
  end

  assign par_en  = ctrl[CT_PEN];
  assign par_odd = ctrl[CT_ODD];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      unique case (addr)
        LOC_DATA: rd_data <= data_q;
        LOC_STAT: rd_data <= {{(DW-ST_N){1'b0}}, flags};
        LOC_CTRL: rd_data <= {{(DW-CT_N){1'b0}}, ctrl};
        default:  rd_data <= div;
      endcase
      irq_rx  <= flags[ST_RDY] & ctrl[CT_IE];
      irq_err <= (flags[ST_OVR] | flags[ST_PER] | flags[ST_FER]) & ctrl[CT_IE];
    end
  end

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> ($stable(data_q) && flags[ST_RDY] && flags[ST_OVR]));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !err.par_err && !err.frm_err) |=> flags[ST_RDY]);

  // R1
  rdy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[ST_RDY]) |-> $past(done));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl[CT_IE] |=> (!irq_rx && !irq_err));
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import srx_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          OSR     = 16,
  parameter logic [DW-1:0] DIV_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq_rx,
  output logic          irq_err
);
  logic          tick;
  logic          done;
  logic [DW-1:0] frame_data;
  rx_err_t       err;
  logic [DW-1:0] div;
  logic          par_en;
  logic          par_odd;

  srx_baud #(.DW(DW)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (div),
    .tick (tick)
  );

  srx_frame #(.DW(DW), .OSR(OSR)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rx      (rx),
    .par_en  (par_en),
    .par_odd (par_odd),
    .done    (done),
    .data    (frame_data),
    .err     (err)
  );

  srx_regs #(.DW(DW), .DIV_RST(DIV_RST)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .done       (done),
    .frame_data (frame_data),
    .err        (err),
    .div        (div),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .rd_data    (rd_data),
    .irq_rx     (irq_rx),
    .irq_err    (irq_err)
  );
endmodule

// File: tb/tb_serial_rx_top.sv
`timescale 1ns/1ps
module tb_serial_rx_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_rx, irq_err;

  int nvec = 0;
  int nfail = 0;
  int bitclk = 16;

  // bench model of the register state
  logic       m_rdy = 0, m_ovr = 0, m_per = 0, m_fer = 0, m_ie = 0;
  logic [7:0] m_data = 8'd0;

  always #4 clk = ~clk;

  serial_rx_top dut (
    .clk(clk), .rst(rst), .rx(rx), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [7:0] exp_stat();
    return {4'b0, m_fer, m_per, m_ovr, m_rdy};
  endfunction

  function automatic logic par_of(input logic [7:0] b, input logic odd);
    return odd ? ~^b : ^b;
  endfunction

  task automatic model_frame(input logic [7:0] b, input logic pe, input logic fe);
    if (m_rdy) m_ovr = 1'b1;
    else begin
      m_data = b;
      if (pe) m_per = 1'b1;
      if (fe) m_fer = 1'b1;
      if (!pe && !fe) m_rdy = 1'b1;
    end
  endtask

  task automatic hold(input logic v);
    rx = v;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic pen, input logic odd,
                      input logic bad_par, input logic bad_stop);
    hold(1'b0);
    for (int i = 0; i < 8; i++) hold(b[i]);
    if (pen) hold(par_of(b, odd) ^ bad_par);
    hold(~bad_stop);
    rx = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    rd(2'd1, d); chk(req, "status", d, exp_stat());
    rd(2'd0, d); chk(req, "data", d, m_data);
    chk(req, "irq_rx", {7'd0, irq_rx}, {7'd0, m_rdy & m_ie});
    chk(req, "irq_err", {7'd0, irq_err}, {7'd0, (m_ovr | m_per | m_fer) & m_ie});
  endtask

  task automatic clear(input logic [3:0] m);
    wr(2'd1, {4'd0, m});
    if (m[0]) m_rdy = 0;
    if (m[1]) m_ovr = 0;
    if (m[2]) m_per = 0;
    if (m[3]) m_fer = 0;
  endtask

  task automatic set_ctrl(input logic pen, input logic odd, input logic ie);
    wr(2'd2, {5'd0, ie, odd, pen});
    m_ie = ie;
  endtask

  initial begin
    #(8ns * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9 reset state, R10 registered reads
    rd(2'd1, d); chk("R9", "status", d, 8'h00);
    rd(2'd0, d); chk("R9", "data", d, 8'h00);
    rd(2'd2, d); chk("R9", "ctrl", d, 8'h00);
    rd(2'd3, d); chk("R9", "div", d, 8'h00);
    chk("R9", "irqs", {6'd0, irq_rx, irq_err}, 8'h00);
    wr(2'd3, 8'h00);
    @(negedge clk); addr = 2'd2; wr_data = 8'h07; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 2'd1;
    d = rd_data; chk("R10", "read lags addr", d, 8'h00);
    @(negedge clk); chk("R10", "status after addr change", rd_data, 8'h00);

    // R1 good frame
    set_ctrl(0, 0, 1);
    send(8'hA5, 0, 0, 0, 0); model_frame(8'hA5, 0, 0);
    check_all("R1");
    // R7 write-one-to-clear
    clear(4'h1);
    check_all("R7");

    // R6 overrun
    send(8'h11, 0, 0, 0, 0); model_frame(8'h11, 0, 0);
    send(8'h3C, 0, 0, 0, 0); model_frame(8'h3C, 0, 0);
    check_all("R6");
    clear(4'hF);

    // R4 parity even failure, odd good
    set_ctrl(1, 0, 1);
    send(8'h96, 1, 0, 1, 0); model_frame(8'h96, 1, 0);
    check_all("R4");
    clear(4'hF);
    set_ctrl(1, 1, 1);
    send(8'h81, 1, 1, 0, 0); model_frame(8'h81, 0, 0);
    check_all("R4");
    clear(4'hF);

    // R5 framing error
    set_ctrl(0, 0, 1);
    send(8'h7E, 0, 0, 0, 1); model_frame(8'h7E, 0, 1);
    check_all("R5");
    clear(4'hF);

    // R2 false start: short low pulse, no change, then a good frame
    rx = 1'b0; repeat (5) @(negedge clk); rx = 1'b1;
    repeat (60) @(negedge clk);
    check_all("R2");
    send(8'hC3, 0, 0, 0, 0); model_frame(8'hC3, 0, 0);
    check_all("R2");
    clear(4'hF);

    // R8 interrupts disabled
    set_ctrl(0, 0, 0);
    send(8'h5A, 0, 0, 0, 1); model_frame(8'h5A, 0, 1);
    check_all("R8");
    clear(4'hF);
    send(8'h24, 0, 0, 0, 0); model_frame(8'h24, 0, 0);
    check_all("R8");
    clear(4'hF);

    // R3 divider 3 -> four clocks per tick
    wr(2'd3, 8'd3);
    rd(2'd3, d); chk("R3", "div", d, 8'd3);
    bitclk = 64;
    send(8'hE7, 0, 0, 0, 0); model_frame(8'hE7, 0, 0);
    check_all("R3");
    clear(4'hF);
    wr(2'd3, 8'd0);
    bitclk = 16;

    // random frames against the model
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      logic pen, odd, ie, bp, bs;
      b = 8'($urandom);
      pen = 1'($urandom); odd = 1'($urandom); ie = 1'($urandom);
      bp = pen && ($urandom % 4 == 0);
      bs = ($urandom % 6 == 0);
      set_ctrl(pen, odd, ie);
      send(b, pen, odd, bp, bs);
      model_frame(b, bp, bs);
      check_all(bs ? "R5" : (bp ? "R4" : (m_ovr ? "R6" : "R1")));
      if ($urandom % 2 == 0) begin
        clear(4'($urandom));
        check_all("R7");
      end
    end

    // R7 sweep a ready-clear across the completion of a second frame
    begin
      int taken = 0, late = 0;
      set_ctrl(0, 0, 1);
      for (int k = 140; k < 172; k++) begin
        logic [7:0] x, y, st, dd;
        x = 8'(k); y = ~8'(k);
        clear(4'hF);
        send(x, 0, 0, 0, 0);
        fork
          begin
            hold(1'b0);
            for (int i = 0; i < 8; i++) hold(y[i]);
            hold(1'b1);
            rx = 1'b1;
          end
          begin
            repeat (k) @(negedge clk);
            wr(2'd1, 8'h01);
          end
        join
        repeat (40) @(negedge clk);
        rd(2'd1, st);
        rd(2'd0, dd);
        nvec++;
        if (st == 8'h01 && dd == y) taken++;
        else if (st == 8'h02 && dd == x) late++;
        else begin
          nfail++;
          $display("FAIL R7 coincident clear k=%0d: got status %h data %h expected 01/%h or 02/%h",
                   k, st, dd, y, x);
        end
      end
      chk("R7", "in-time outcomes seen", {7'd0, taken > 0}, 8'd1);
      chk("R7", "late outcomes seen", {7'd0, late > 0}, 8'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule